// File: doc/BRIEF.md
# Dual-Mode Pulse-Swallow Frequency Divider

This block divides a stream of input events by a programmable ratio and marks the end of each divided period. The events arrive as a clock-enable strobe, `tick_in`, sampled on one system clock. A one-cycle output pulse is raised once every K events. A square monitor output toggles on every such pulse.

The ratio comes from one setting word, read according to a two-bit mode input. In the two swallow modes the divider behaves like a divide-by-16/17 prescaler followed by a main counter. A 4-bit swallow count A selects how many prescaler rounds last 17 events, and the remaining rounds last 16 events. Over a main count of N rounds this gives K = 16·N + A. The wide swallow mode takes a 14-bit N and suits the comparator path. The narrow swallow mode takes a 13-bit N and suits the high-speed reference path. In the direct modes a single 17-bit count R gives K = R, which suits the low-speed reference path.

A new setting is adopted only when a period completes, or when the divider is armed. Changes made during a period therefore never produce a short or glitched period. A setting below the mode's minimum ratio is flagged, and the outputs stay low while it persists. Driving the enable input low clears the divider.

Top module: `swallow_divider`

## Requirements
- R1: With mode 0 (wide swallow), N = div_word[17:4] and A = div_word[3:0]. Exactly K = 16·N + A counted ticks separate consecutive output pulses.
- R2: With mode 1 (narrow swallow), N = div_word[16:4] and A = div_word[3:0], and div_word[17] has no effect. The ratio is K = 16·N + A.
- R3: With mode 2 or mode 3 (direct), K = div_word[16:0], and div_word[17] has no effect.
- R4: A swallow setting is legal only when N > A and 16·N + A ≥ 272. A direct setting is legal only when R ≥ 6. When an illegal setting is loaded, cfg_bad is 1 from the next cycle, and div_pulse and div_square stay 0. Presenting a legal word clears cfg_bad one cycle later, and counting then restarts.
- R5: div_pulse is high for exactly one cycle. It is high in the cycle after the clock edge that samples the K-th tick of a period. Only cycles with tick_in high are counted.
- R6: div_square is 0 after reset and after arming. It toggles together with every pulse.
- R7: Mode and div_word are loaded only at arming and at the edge that ends a period. A change during a period first affects the following period.
- R8: With en low, div_pulse, div_square and cfg_bad are 0 from the next cycle, and the count restarts. In the first enabled cycle after reset or after en was low, the setting is loaded and tick_in is ignored.
- R9: While rst is high, div_pulse, div_square and cfg_bad are 0 after the next clock edge.
- R10: An illegal setting loaded at a period end suppresses that period's pulse. cfg_bad rises in the same cycle that the pulse would have appeared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears the counters and outputs |
| tick_in | input | 1 | Input event strobe, one event per high cycle |
| mode | input | 2 | 0 wide swallow, 1 narrow swallow, 2/3 direct count |
| div_word | input | 18 | Setting word, with fields decoded by mode |
| div_pulse | output | 1 | One-cycle pulse at the end of each period |
| div_square | output | 1 | Square monitor output, toggling on each pulse |
| cfg_bad | output | 1 | Loaded setting is illegal |

## Verification
The hardest case to reach is a setting change that lands on a period boundary. This is especially hard when the new word is illegal, because the pulse that would close the period must then vanish as cfg_bad rises. The stimulus counts ticks itself, with random gaps between them. It rewrites the setting halfway through a period, including a switch between swallow and direct modes. It also writes an illegal word during a period and checks the exact sample at which the K-th tick lands. Boundary ratios of 271, 272, 5 and 6 are applied as directed cases.

// File: rtl/swd_pkg.sv
`timescale 1ns/1ps
package swd_pkg;
  localparam int unsigned SWD_N_W   = 14;  // wide main count
  localparam int unsigned SWD_NR_W  = 13;  // narrow main count
  localparam int unsigned SWD_A_W   = 4;   // swallow count
  localparam int unsigned SWD_R_W   = 17;  // direct count
  localparam int unsigned SWD_MIN_SW  = 272;
  localparam int unsigned SWD_MIN_DIR = 6;

  typedef enum logic [1:0] {
    MODE_WIDE       = 2'd0,
    MODE_NARROW     = 2'd1,
    MODE_DIRECT     = 2'd2,
    MODE_DIRECT_ALT = 2'd3
  } div_mode_e;
endpackage

// File: rtl/swd_cfg_check.sv
`timescale 1ns/1ps
// Decodes the setting word for the selected mode and judges legality.
module swd_cfg_check #(
  parameter int unsigned N_W     = 14,
  parameter int unsigned NR_W    = 13,
  parameter int unsigned A_W     = 4,
  parameter int unsigned R_W     = 17,
  parameter int unsigned MIN_SW  = 272,
  parameter int unsigned MIN_DIR = 6,
  localparam int unsigned WORD_W = N_W + A_W,
  localparam int unsigned MAIN_W = (R_W > N_W) ? R_W : N_W
) (
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] word,
  output logic [MAIN_W-1:0] main_ld,
  output logic [A_W-1:0]    swal_ld,
  output logic              direct,
  output logic              legal
);
  import swd_pkg::*;
  localparam int unsigned RAT_W = MAIN_W + A_W;

  div_mode_e         m;
  logic [MAIN_W-1:0] n_sel;
  logic [MAIN_W-1:0] r_val;
  logic [A_W-1:0]    a_val;
  logic [RAT_W-1:0]  ratio;

  always_comb begin
    m      = div_mode_e'(mode);
    a_val  = word[A_W-1:0];
    r_val  = MAIN_W'(word[R_W-1:0]);
    n_sel  = (m == MODE_NARROW) ? MAIN_W'(word[A_W+NR_W-1:A_W])
                                : MAIN_W'(word[WORD_W-1:A_W]);
    ratio  = (RAT_W'(n_sel) << A_W) + RAT_W'(a_val);
    direct = (m == MODE_DIRECT) || (m == MODE_DIRECT_ALT);
    main_ld = direct ? r_val : n_sel;
    swal_ld = direct ? '0 : a_val;
    legal   = direct ? (r_val >= MAIN_W'(MIN_DIR))
                     : ((n_sel > MAIN_W'(a_val)) && (ratio >= RAT_W'(MIN_SW)));
  end
endmodule

// File: rtl/swd_prescaler.sv
`timescale 1ns/1ps
// Dual-modulus prescaler with its swallow counter: rounds of 2^A_W+1 ticks
// while the swallow count is nonzero, 2^A_W ticks afterwards.
module swd_prescaler #(
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           tick,
  input  logic [A_W-1:0] swal_ld,
  output logic           wrap
);
  localparam int unsigned PRE_W = A_W + 1;
  localparam logic [PRE_W-1:0] LAST_LO = PRE_W'((1 << A_W) - 1);
  localparam logic [PRE_W-1:0] LAST_HI = PRE_W'(1 << A_W);

  logic [PRE_W-1:0] pcnt;
  logic [A_W-1:0]   scnt;
  logic [PRE_W-1:0] last;

  always_comb begin
    last = (scnt != '0) ? LAST_HI : LAST_LO;
    wrap = tick && (pcnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      scnt <= '0;
    end else if (clr) begin
      pcnt <= '0;
      scnt <= swal_ld;
    end else if (tick) begin
      if (pcnt == last) begin
        pcnt <= '0;
        if (scnt != '0) scnt <= scnt - A_W'(1);
      end else begin
        pcnt <= pcnt + PRE_W'(1);
      end
    end
  end

  // R1: prescaler position never passes the long-round terminal value
  a_r1_pre_range: assert property (@(posedge clk) disable iff (rst)
    pcnt <= LAST_HI);
  // R1: once the swallow count has run out, rounds are short
  a_r1_short_after_swallow: assert property (@(posedge clk) disable iff (rst)
    (scnt == '0) && !clr |-> pcnt <= LAST_LO);
endmodule

// File: rtl/swd_main_cnt.sv
`timescale 1ns/1ps
// Main down-counter: reloads on clr, steps once per prescaler round
// (swallow modes) or per tick (direct modes).
module swd_main_cnt #(
  parameter int unsigned MAIN_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic [MAIN_W-1:0] ld,
  output logic              done
);
  logic [MAIN_W-1:0] mcnt;

  assign done = step && (mcnt == MAIN_W'(1));

  always_ff @(posedge clk) begin
    if (rst)       mcnt <= '0;
    else if (clr)  mcnt <= ld;
    else if (step) mcnt <= mcnt - MAIN_W'(1);
  end

  // R5: a running count never steps from zero
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    !clr && step |-> mcnt != '0);
endmodule

// File: rtl/swallow_divider.sv
`timescale 1ns/1ps
module swallow_divider #(
  parameter int unsigned N_W     = swd_pkg::SWD_N_W,
  parameter int unsigned NR_W    = swd_pkg::SWD_NR_W,
  parameter int unsigned A_W     = swd_pkg::SWD_A_W,
  parameter int unsigned R_W     = swd_pkg::SWD_R_W,
  parameter int unsigned MIN_SW  = swd_pkg::SWD_MIN_SW,
  parameter int unsigned MIN_DIR = swd_pkg::SWD_MIN_DIR,
  localparam int unsigned WORD_W = N_W + A_W,
  localparam int unsigned MAIN_W = (R_W > N_W) ? R_W : N_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick_in,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] div_word,
  output logic              div_pulse,
  output logic              div_square,
  output logic              cfg_bad
);
  logic [MAIN_W-1:0] main_ld;
  logic [A_W-1:0]    swal_ld;
  logic              direct_in, legal_in;
  logic              run_q, direct_q;
  logic              wrap, step, done, period_end;
  logic              clr_main, clr_pre;

  swd_cfg_check #(
    .N_W(N_W), .NR_W(NR_W), .A_W(A_W), .R_W(R_W),
    .MIN_SW(MIN_SW), .MIN_DIR(MIN_DIR)
  ) u_cfg (
    .mode(mode), .word(div_word), .main_ld(main_ld), .swal_ld(swal_ld),
    .direct(direct_in), .legal(legal_in)
  );

  always_comb begin
    step       = run_q && (direct_q ? tick_in : wrap);
    period_end = en && run_q && done;
    clr_main   = !en || !run_q || period_end;
    clr_pre    = clr_main || direct_q;
  end

  swd_prescaler #(.A_W(A_W)) u_pre (
    .clk(clk), .rst(rst), .clr(clr_pre), .tick(tick_in),
    .swal_ld(swal_ld), .wrap(wrap)
  );

  swd_main_cnt #(.MAIN_W(MAIN_W)) u_main (
    .clk(clk), .rst(rst), .clr(clr_main), .step(step),
    .ld(main_ld), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      direct_q   <= 1'b0;
      cfg_bad    <= 1'b0;
      div_pulse  <= 1'b0;
      div_square <= 1'b0;
    end else if (!en) begin
      run_q      <= 1'b0;
      cfg_bad    <= 1'b0;
      div_pulse  <= 1'b0;
      div_square <= 1'b0;
    end else if (!run_q || period_end) begin
      run_q      <= legal_in;
      cfg_bad    <= !legal_in;
      direct_q   <= direct_in;
      div_pulse  <= period_end && legal_in;
      div_square <= legal_in ? (div_square ^ period_end) : 1'b0;
    end else begin
      div_pulse  <= 1'b0;
    end
  end

  // R8: disabling clears every output on the next cycle
  a_r8_en_clears: assert property (@(posedge clk) disable iff (rst)
    !en |=> !div_pulse && !div_square && !cfg_bad);
  // R4: an illegal setting keeps both outputs low
  a_r4_bad_silent: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |-> !div_pulse && !div_square);
  // R5: the pulse lasts one cycle
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
  // R6: the square output flips together with each pulse
  a_r6_square_toggles: assert property (@(posedge clk) disable iff (rst)
    $rose(div_pulse) |-> div_square != $past(div_square));
  // R7: the mode in use holds for the whole of a period
  a_r7_mode_held: assert property (@(posedge clk) disable iff (rst)
    en && run_q && !period_end |=> $stable(direct_q));
endmodule

// File: tb/swallow_divider_bench.sv
`timescale 1ns/1ps
module swallow_divider_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [17:0] word = '0;
  logic        div_pulse, div_square, cfg_bad;

  int n_cmp = 0;
  int n_bad = 0;
  bit sq_exp = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  swallow_divider u_swallow_divider (
    .clk(clk), .rst(rst), .en(en), .tick_in(tick), .mode(mode),
    .div_word(word), .div_pulse(div_pulse), .div_square(div_square),
    .cfg_bad(cfg_bad)
  );

  function automatic int unsigned ratio_of(logic [1:0] m, logic [17:0] w);
    if (m[1]) return int'(w[16:0]);
    if (m == 2'd1) return int'(w[16:4]) * 16 + int'(w[3:0]);
    return int'(w[17:4]) * 16 + int'(w[3:0]);
  endfunction

  function automatic bit legal_of(logic [1:0] m, logic [17:0] w);
    int unsigned n;
    if (m[1]) return ratio_of(m, w) >= 6;
    n = (m == 2'd1) ? int'(w[16:4]) : int'(w[17:4]);
    return (n > int'(w[3:0])) && (ratio_of(m, w) >= 272);
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit t);
    tick = t;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic arm(logic [1:0] m, logic [17:0] w);
    mode = m; word = w; en = 1'b1;
    cyc(1'b1);            // R8: tick in the arming cycle is ignored
    sq_exp = 1'b0;
  endtask

  task automatic disarm();
    en = 1'b0;
    cyc(1'b0);
  endtask

  task automatic rand_legal(output logic [1:0] m, output logic [17:0] w);
    m = 2'($urandom % 4);
    if (m[1]) w = {1'($urandom % 2), 17'(6 + $urandom % 700)};
    else if (m == 2'd1) w = {1'($urandom % 2), 13'(17 + $urandom % 30), 4'($urandom % 16)};
    else w = {14'(17 + $urandom % 30), 4'($urandom % 16)};
  endtask

  // Counts ticks between pulses; optionally rewrites the setting mid-period.
  task automatic run_periods(string req, int nper, int gap_pct, bit mid,
                             logic [1:0] nm, logic [17:0] nw);
    int unsigned k = ratio_of(mode, word);
    int unsigned nt = 0;
    int got = 0;
    bit changed = 1'b0;
    bit t;
    while (got < nper && !finished) begin
      t = (($urandom % 100) >= gap_pct);
      cyc(t);
      if (t) nt++;
      if (div_pulse) begin
        check({req, " ticks per period"}, int'(nt), int'(k));
        sq_exp = ~sq_exp;
        check("R6 square toggles", int'(div_square), int'(sq_exp));
        nt = 0; got++; changed = 1'b0;
        k = ratio_of(mode, word);
      end else if (nt >= k) begin
        check({req, " missing pulse"}, int'(nt), int'(k) + 1);
        got = nper;
      end
      if (mid && !changed && nt == k / 2 && nt > 0) begin
        mode = nm; word = nw; changed = 1'b1;   // R7
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0]  m, m2;
    logic [17:0] w, w2;
    bit quiet;
    int unsigned k;
    int unsigned nt;
    void'($urandom(32'd20240611));

    @(negedge clk);
    cyc(1'b1); cyc(1'b1);
    check("R9 reset pulse", int'(div_pulse), 0);
    check("R9 reset square", int'(div_square), 0);
    check("R9 reset bad", int'(cfg_bad), 0);
    rst = 1'b0;

    // R1 minimum legal wide ratio 272 (N=17, A=0)
    arm(2'd0, {14'd17, 4'd0});
    check("R8 armed not bad", int'(cfg_bad), 0);
    run_periods("R1", 2, 0, 1'b0, 2'd0, '0);
    disarm();

    // R1 with swallow count, random gaps
    arm(2'd0, {14'd20, 4'd15});
    run_periods("R1", 3, 40, 1'b0, 2'd0, '0);
    disarm();

    // R2 narrow: bit 17 set has no effect
    arm(2'd1, {1'b1, 13'd20, 4'd7});
    run_periods("R2", 2, 25, 1'b0, 2'd0, '0);
    disarm();

    // R3 direct boundary 6, bit 17 set, mode 3
    arm(2'd3, {1'b1, 17'd6});
    run_periods("R3", 3, 0, 1'b0, 2'd0, '0);
    disarm();

    // R4 illegal: ratio 271, then N == A, then direct 5
    arm(2'd0, {14'd16, 4'd15});
    check("R4 bad 271", int'(cfg_bad), 1);
    quiet = 1'b1;
    for (int i = 0; i < 600; i++) begin
      cyc(1'b1);
      if (div_pulse || div_square || !cfg_bad) quiet = 1'b0;
    end
    check("R4 silent while bad", int'(quiet), 1);
    word = {14'd15, 4'd15}; cyc(1'b0);
    check("R4 bad N==A", int'(cfg_bad), 1);
    mode = 2'd2; word = 18'd5; cyc(1'b0);
    check("R4 bad direct 5", int'(cfg_bad), 1);
    word = 18'd9; cyc(1'b0);
    check("R4 recovers", int'(cfg_bad), 0);
    sq_exp = 1'b0;
    run_periods("R4", 2, 10, 1'b0, 2'd0, '0);

    // R7 mid-period change across modes: direct -> wide
    run_periods("R7", 2, 20, 1'b1, 2'd0, {14'd18, 4'd3});
    disarm();

    // R10 illegal word loaded at a period end
    arm(2'd0, {14'd17, 4'd5});
    k = ratio_of(mode, word);
    nt = 0;
    while (nt < k - 1) begin
      cyc(1'b1); nt++;
      if (nt == 10) word = {14'd3, 4'd1};
    end
    check("R10 no pulse before end", int'(div_pulse), 0);
    cyc(1'b1);
    check("R10 pulse suppressed", int'(div_pulse), 0);
    check("R10 bad rises", int'(cfg_bad), 1);
    check("R10 square low", int'(div_square), 0);
    disarm();

    // R8 enable drop mid-period restarts the count
    arm(2'd0, {14'd19, 4'd2});
    for (int i = 0; i < 100; i++) cyc(1'b1);
    en = 1'b0;
    cyc(1'b1); cyc(1'b1);
    check("R8 pulse low while disabled", int'(div_pulse), 0);
    check("R8 square low while disabled", int'(div_square), 0);
    arm(2'd0, {14'd19, 4'd2});
    run_periods("R8", 1, 0, 1'b0, 2'd0, '0);
    disarm();

    // Random legal settings with mid-period rewrites
    for (int it = 0; it < 12; it++) begin
      rand_legal(m, w);
      rand_legal(m2, w2);
      arm(m, w);
      run_periods(m[1] ? "R3" : (m == 2'd1 ? "R2" : "R1"), 3, 30, 1'b1, m2, w2);
      check("R4 legal random", int'(legal_of(m2, w2)), 1);
      disarm();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule